// File: doc/BRIEF.md
# Odd Parity Generator with Shift/Hold Output Register

The block forms the odd parity of a parameterised group of data bits (twelve by default) and presents it at once on a direct output and on that output's complement. A gate input pulls the direct output low whatever the data are. This is useful when a parity lane has to be silenced without touching the data.

A single-bit output register follows the direct output and has its own true and complement outputs. Two selectors in series pick what the register takes next. The first selector either feeds the register's own value back, so the register holds, or passes the gated parity bit. The second selector either passes that result or substitutes a serial input bit, so several of these blocks can be chained as a shift path.

The register captures on a rising edge of either of two clock inputs, because the two clocks are ORed into one capture clock. An active-high asynchronous reset clears the register.

Top module: `parity_shift_reg`

## Requirements
- R1: `q` is 1 when an odd number of `din` bits are 1, and 0 when the count is even, including zero and all-ones with the default width of 12, provided `force_low` is 0.
- R2: While `force_low` is 1, `q` is 0 for every `din` pattern.
- R3: With `shift_sel` 0 and `keep_n` 0, a capture edge leaves `y` unchanged.
- R4: With `shift_sel` 0 and `keep_n` 1, a capture edge loads the current `q` into `y`.
- R5: With `shift_sel` 1, a capture edge loads `ser_in` into `y`, whatever the value of `keep_n`.
- R6: A rising edge on `clk_a` alone, or on `clk_b` alone, is a capture edge.
- R7: A load with `force_low` at 1 stores 0 in `y`, even if the data parity is odd.
- R8: `rst` at 1 drives `y` to 0 without any clock edge, and capture edges while `rst` stays at 1 leave `y` at 0.
- R9: `q_n` is always the inverse of `q`, and `y_n` is always the inverse of `y`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | WIDTH | Data bits whose parity is formed |
| force_low | input | 1 | 1 forces the direct output low |
| keep_n | input | 1 | 0 selects hold, 1 selects load of the gated parity |
| shift_sel | input | 1 | 1 selects the serial input for the register |
| ser_in | input | 1 | Serial data bit |
| clk_a | input | 1 | First capture clock |
| clk_b | input | 1 | Second capture clock |
| rst | input | 1 | Asynchronous active-high register clear |
| q | output | 1 | Gated odd parity |
| q_n | output | 1 | Complement of q |
| y | output | 1 | Registered bit |
| y_n | output | 1 | Complement of y |

## Verification
The bench builds the block with the default WIDTH of 12. This width puts the all-ones pattern, which has an even count, and each single-bit pattern within a handful of vectors. It also keeps random patterns spread evenly across odd and even counts. Random vectors mix all four selector settings, the gate, and a random choice between the two clocks, so every path into the register is reached through each clock. Reset is applied both without any clock edge and with edges arriving during reset.

// File: rtl/parity_shift_reg.sv
`timescale 1ns/1ps
module parity_shift_reg #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] din,
  input  logic             force_low,
  input  logic             keep_n,
  input  logic             shift_sel,
  input  logic             ser_in,
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst,
  output logic             q,
  output logic             q_n,
  output logic             y,
  output logic             y_n
);
  logic cap_clk, loop_bit, next_bit;

  assign q        = (^din) & ~force_low;
  assign q_n      = ~q;
  assign loop_bit = keep_n ? q : y;
  assign next_bit = shift_sel ? ser_in : loop_bit;
  assign cap_clk  = clk_a | clk_b;

  always_ff @(posedge cap_clk or posedge rst)
    if (rst) y <= 1'b0;
    else     y <= next_bit;

  assign y_n = ~y;

  // set by reset, cleared by the next capture edge
  logic rst_seen;
  always_ff @(posedge cap_clk or posedge rst)
    if (rst) rst_seen <= 1'b1;
    else     rst_seen <= 1'b0;

  p_gate_low_r2: assert property (@(posedge cap_clk) force_low |-> !q);
  p_reset_clears_r8: assert property (@(posedge cap_clk) rst |-> !y);
  p_hold_keeps_r3: assert property (@(posedge cap_clk) disable iff (rst)
    (!shift_sel && !keep_n) |=> (rst_seen || $stable(y)));
  p_load_parity_r4: assert property (@(posedge cap_clk) disable iff (rst)
    (!shift_sel && keep_n) |=> (rst_seen || y == $past(q)));
  p_shift_capture_r5: assert property (@(posedge cap_clk) disable iff (rst)
    shift_sel |=> (rst_seen || y == $past(ser_in)));
endmodule

// File: tb/tb_parity_shift_reg.sv
`timescale 1ns/1ps
module tb_parity_shift_reg;
  localparam int W = 12;
  typedef struct { bit is_reg; logic exp; string req; } item_t;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic [W-1:0] din = '0;
  logic force_low = 0, keep_n = 0, shift_sel = 0, ser_in = 0;
  logic clk_a = 0, clk_b = 0, rst = 1;
  logic q, q_n, y, y_n;

  parity_shift_reg #(.WIDTH(W)) dut (
    .din(din), .force_low(force_low), .keep_n(keep_n), .shift_sel(shift_sel),
    .ser_in(ser_in), .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
    .q(q), .q_n(q_n), .y(y), .y_n(y_n));

  item_t sb[$];
  int applied = 0, bad = 0;
  logic model_y = 0;
  bit done = 0;

  // monitor: pops each expected item and compares against the ports
  initial forever begin
    item_t it;
    wait (sb.size() != 0);
    it = sb.pop_front();
    applied++;
    if (it.is_reg) begin
      if (y !== it.exp || y_n !== ~it.exp) begin
        bad++;
        $display("FAIL %s (R9 pair): y=%b y_n=%b expected %b/%b", it.req, y, y_n, it.exp, ~it.exp);
      end
    end else begin
      if (q !== it.exp || q_n !== ~it.exp) begin
        bad++;
        $display("FAIL %s (R9 pair): q=%b q_n=%b expected %b/%b", it.req, q, q_n, it.exp, ~it.exp);
      end
    end
  end

  task automatic push(bit is_reg, logic e, string r);
    item_t it;
    it.is_reg = is_reg; it.exp = e; it.req = r;
    sb.push_back(it);
    #1;
  endtask

  task automatic pulse(bit use_b);
    if (use_b) clk_b = 1; else clk_a = 1;
    #1;
    clk_a = 0; clk_b = 0;
    #1;
  endtask

  task automatic apply(logic [W-1:0] d, logic fl, logic kn, logic sh, logic si, bit use_b);
    logic eq;
    string r;
    @(posedge clk);
    din = d; force_low = fl; keep_n = kn; shift_sel = sh; ser_in = si;
    #1;
    eq = fl ? 1'b0 : ($countones(d) % 2 == 1);
    push(0, eq, fl ? "R2" : "R1");
    if (sh) begin model_y = si; r = "R5"; end
    else if (kn) begin model_y = eq; r = fl ? "R7" : "R4"; end
    else r = "R3";
    pulse(use_b);
    push(1, model_y, use_b ? {r, "/R6 clk_b"} : {r, "/R6 clk_a"});
  endtask

  task automatic do_reset();
    @(posedge clk);
    rst = 1; #1;
    model_y = 0;
    push(1, 1'b0, "R8 async");
    shift_sel = 1; ser_in = 1;
    pulse(0);
    push(1, 1'b0, "R8 edge during reset");
    pulse(1);
    push(1, 1'b0, "R8 edge during reset");
    rst = 0; #1;
  endtask

  initial begin
    #1;
    push(1, 1'b0, "R8 reset state");
    rst = 0;
    // directed corners
    apply('0, 0, 1, 0, 0, 0);            // zero ones: even, R1
    apply('1, 0, 1, 0, 0, 1);            // twelve ones: even, R1
    for (int i = 0; i < W; i++) apply(W'(1) << i, 0, 1, 0, 0, i % 2 == 1);
    apply(12'h001, 0, 0, 0, 0, 0);       // hold a 1, R3
    apply(12'h000, 0, 0, 0, 0, 1);
    apply(12'h007, 1, 1, 0, 0, 0);       // odd data gated, load 0, R7
    apply(12'h000, 0, 0, 1, 1, 1);       // shift in over hold, R5
    apply(12'h000, 0, 1, 1, 0, 0);       // shift in over load, R5
    do_reset();
    for (int n = 0; n < 400; n++) begin
      apply(W'($urandom), ($urandom % 4) == 0, $urandom % 2, ($urandom % 3) == 0,
            $urandom % 2, $urandom % 2);
      if (n % 100 == 50) do_reset();
    end
    wait (sb.size() == 0);
    #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule